// File: doc/BRIEF.md
# PWM Period and On-Time Capture

This block times a digital input waveform using a free-running clock-cycle counter. The counter restarts on every active edge of the input. Its value at that edge is the period of the cycle just finished. Its value at the opposite edge is the on-time of the pulse now ending. The input must already be synchronous to the clock. A polarity select chooses whether high or low is the active level.

A single start pulse, together with a mode select, arms one of three measurements:

- **Continuous** mode keeps publishing the latest period and on-time pair.
- **Burst** mode adds a programmed number of cycles into two wide sums and then stops.
- **Single-pulse** mode times one active pulse and then stops.

A start with the idle code aborts the current measurement. While a measurement runs, `busy` is high. A one-cycle `done` marks the moment when burst or single-pulse results become valid.

Top module: `pwm_capture`

## Requirements
- R1: After reset, `busy`, `done`, the pair outputs, the cycle count and both sums are all zero.
- R2: With `active_high` = 1 the active edge is rising and the on-time ends at a falling edge; with `active_high` = 0 the roles are swapped.
- R3: `mode_sel` codes are 0 idle, 1 continuous, 2 burst, 3 single pulse. In continuous mode the first active edge after start is discarded. Every later active edge publishes two values: the clock cycles since the previous active edge on `period_q`, and the cycles from that previous active edge to the opposite edge on `ontime_q`.
- R4: Starting continuous or burst mode clears `period_q`, `ontime_q`, `burst_count` and both sums to zero in the cycle after the start.
- R5: In burst mode the first active edge is discarded. Each later active edge adds the period to `period_sum` and the latest on-time to `ontime_sum`, and increments `burst_count`. When the count reaches the target, `done` pulses for one cycle and `busy` falls in that same cycle.
- R6: A burst target of zero behaves as a target of one.
- R7: In single-pulse mode no edge is discarded. At the first opposite edge, `ontime_q` takes the cycles since the last active edge (or since start), `done` pulses and the block stops. Later edges change nothing.
- R8: A start with `mode_sel` = 0 aborts at once: `busy` falls and no `done` follows. Results keep their values, and later input edges do not change them.
- R9: A start that selects the mode already running has no effect: results are not cleared and `busy` stays high.
- R10: While `busy` is low and no start is given, every result output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Measured waveform, already synchronous |
| active_high | input | 1 | 1: high is the active level; 0: low is the active level |
| mode_sel | input | 2 | Mode applied at start: 0 idle, 1 continuous, 2 burst, 3 single |
| burst_target | input | TGT_W | Number of cycles to add in burst mode (0 treated as 1) |
| start | input | 1 | One-cycle pulse that applies `mode_sel` |
| period_q | output | CNT_W | Latest period (continuous) |
| ontime_q | output | CNT_W | Latest on-time (continuous, single pulse) |
| burst_count | output | TGT_W | Cycles added in burst mode |
| period_sum | output | SUM_W | Sum of burst periods |
| ontime_sum | output | SUM_W | Sum of burst on-times |
| done | output | 1 | One-cycle pulse when burst or single-pulse results are valid |
| busy | output | 1 | High while a measurement runs |

## Verification
The properties take several things about the inputs for granted:

- `start` is a single-cycle pulse.
- `sig_in` changes only between clock edges.
- Each input level lasts at least one clock.

The bench drives every input on the falling clock edge and keeps all pulse and gap lengths at one cycle or more. It always returns the signal to its inactive level before arming a measurement, so that single-pulse results cover a whole pulse. Results are sampled a few cycles after the edge that should produce them.

// File: rtl/pwm_cap_pkg.sv
package pwm_cap_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_CONT   = 2'd1,
    MODE_BURST  = 2'd2,
    MODE_SINGLE = 2'd3
  } cap_mode_e;
endpackage

// File: rtl/pwm_edge_detect.sv
module pwm_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  input  logic active_high,
  output logic act_edge,
  output logic opp_edge
);
  logic prev_q;
  logic changed;

  // Reset loads the current level so no false edge follows reset.
  always_ff @(posedge clk) begin
    prev_q <= sig_in;
  end

  assign changed  = (sig_in ^ prev_q) & ~rst;
  assign act_edge = changed & (sig_in == active_high);
  assign opp_edge = changed & (sig_in != active_high);
endmodule

// File: rtl/pwm_cycle_counter.sv
module pwm_cycle_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);
  // Restart loads one so that the value seen at the next edge equals
  // the number of clocks between the two edges. Wraps at all ones.
  always_ff @(posedge clk) begin
    if (rst || clear)
      count <= '0;
    else if (restart)
      count <= CNT_W'(1);
    else
      count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/pwm_accumulate.sv
module pwm_accumulate #(
  parameter int CNT_W = 32,
  parameter int SUM_W = 64,
  parameter int TGT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             add,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] ontime_in,
  output logic [SUM_W-1:0] period_sum,
  output logic [SUM_W-1:0] ontime_sum,
  output logic [TGT_W-1:0] cycles
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      period_sum <= '0;
      ontime_sum <= '0;
      cycles     <= '0;
    end else if (add) begin
      period_sum <= period_sum + SUM_W'(period_in);
      ontime_sum <= ontime_sum + SUM_W'(ontime_in);
      cycles     <= cycles + TGT_W'(1);
    end
  end
endmodule

// File: rtl/pwm_capture.sv
module pwm_capture
  import pwm_cap_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SUM_W = 64,
  parameter int TGT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_in,
  input  logic             active_high,
  input  logic [1:0]       mode_sel,
  input  logic [TGT_W-1:0] burst_target,
  input  logic             start,
  output logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] ontime_q,
  output logic [TGT_W-1:0] burst_count,
  output logic [SUM_W-1:0] period_sum,
  output logic [SUM_W-1:0] ontime_sum,
  output logic             done,
  output logic             busy
);
  localparam logic [TGT_W-1:0] TGT_ONE = TGT_W'(1);

  cap_mode_e        mode_q;
  cap_mode_e        req_mode;
  logic             skip_q;
  logic [CNT_W-1:0] ontime_lat;
  logic [TGT_W-1:0] target_q;
  logic             act_edge, opp_edge;
  logic [CNT_W-1:0] cnt;
  logic             accept, arm, acc_add, last_cycle;

  assign req_mode = cap_mode_e'(mode_sel);
  assign accept   = start && (req_mode != mode_q);
  assign arm      = accept && (req_mode == MODE_CONT || req_mode == MODE_BURST);
  assign acc_add  = !accept && (mode_q == MODE_BURST) && act_edge && !skip_q;
  assign last_cycle = acc_add &&
                      ({1'b0, burst_count} + {{TGT_W{1'b0}}, 1'b1} == {1'b0, target_q});

  pwm_edge_detect u_edge (
    .clk        (clk),
    .rst        (rst),
    .sig_in     (sig_in),
    .active_high(active_high),
    .act_edge   (act_edge),
    .opp_edge   (opp_edge)
  );

  pwm_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .restart(act_edge),
    .count  (cnt)
  );

  pwm_accumulate #(.CNT_W(CNT_W), .SUM_W(SUM_W), .TGT_W(TGT_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .clear     (arm),
    .add       (acc_add),
    .period_in (cnt),
    .ontime_in (ontime_lat),
    .period_sum(period_sum),
    .ontime_sum(ontime_sum),
    .cycles    (burst_count)
  );

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      mode_q     <= MODE_IDLE;
      busy       <= 1'b0;
      skip_q     <= 1'b0;
      ontime_lat <= '0;
      period_q   <= '0;
      ontime_q   <= '0;
      target_q   <= TGT_ONE;
    end else if (accept) begin
      mode_q <= req_mode;
      case (req_mode)
        MODE_IDLE: begin
          busy <= 1'b0;
        end
        MODE_SINGLE: begin
          busy   <= 1'b1;
          skip_q <= 1'b0;
        end
        default: begin
          busy       <= 1'b1;
          skip_q     <= 1'b1;
          ontime_lat <= '0;
          period_q   <= '0;
          ontime_q   <= '0;
          target_q   <= (burst_target == '0) ? TGT_ONE : burst_target;
        end
      endcase
    end else begin
      case (mode_q)
        MODE_CONT: begin
          if (act_edge) begin
            if (skip_q) begin
              skip_q <= 1'b0;
            end else begin
              period_q <= cnt;
              ontime_q <= ontime_lat;
            end
          end
          if (opp_edge) ontime_lat <= cnt;
        end
        MODE_BURST: begin
          if (act_edge && skip_q) skip_q <= 1'b0;
          if (opp_edge) ontime_lat <= cnt;
          if (last_cycle) begin
            done   <= 1'b1;
            busy   <= 1'b0;
            mode_q <= MODE_IDLE;
          end
        end
        MODE_SINGLE: begin
          if (opp_edge) begin
            ontime_q <= cnt;
            done     <= 1'b1;
            busy     <= 1'b0;
            mode_q   <= MODE_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_capture_chk.sv
module pwm_capture_chk #(
  parameter int CNT_W = 32,
  parameter int SUM_W = 64,
  parameter int TGT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [1:0]       mode_sel,
  input logic             done,
  input logic             busy,
  input logic [CNT_W-1:0] period_q,
  input logic [CNT_W-1:0] ontime_q,
  input logic [TGT_W-1:0] burst_count,
  input logic [SUM_W-1:0] period_sum,
  input logic [SUM_W-1:0] ontime_sum
);
  // R5: done lasts a single cycle
  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: busy is already low when done is shown
  p_done_not_busy_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: an idle start stops the block with no completion
  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (start && mode_sel == 2'd0) |=> (!busy && !done));

  // R3: a start that names a measurement leaves the block busy
  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (start && mode_sel != 2'd0) |=> busy);

  // R10: results hold while idle
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(period_q) && $stable(ontime_q) &&
      $stable(burst_count) && $stable(period_sum) && $stable(ontime_sum)));
endmodule

bind pwm_capture pwm_capture_chk #(.CNT_W(CNT_W), .SUM_W(SUM_W), .TGT_W(TGT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .mode_sel   (mode_sel),
  .done       (done),
  .busy       (busy),
  .period_q   (period_q),
  .ontime_q   (ontime_q),
  .burst_count(burst_count),
  .period_sum (period_sum),
  .ontime_sum (ontime_sum)
);

// File: tb/pwm_capture_test.sv
module pwm_capture_test;
  localparam int CNT_W = 32;
  localparam int SUM_W = 64;
  localparam int TGT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sig_in = 1'b0;
  logic             active_high = 1'b1;
  logic [1:0]       mode_sel = 2'd0;
  logic [TGT_W-1:0] burst_target = '0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] period_q, ontime_q;
  logic [TGT_W-1:0] burst_count;
  logic [SUM_W-1:0] period_sum, ontime_sum;
  logic             done, busy;

  int n_checks = 0;
  int n_err = 0;
  int done_cnt = 0;
  int on_len[8];
  int off_len[8];

  always #4 clk = ~clk;

  pwm_capture #(.CNT_W(CNT_W), .SUM_W(SUM_W), .TGT_W(TGT_W)) uut (
    .clk(clk), .rst(rst), .sig_in(sig_in), .active_high(active_high),
    .mode_sel(mode_sel), .burst_target(burst_target), .start(start),
    .period_q(period_q), .ontime_q(ontime_q), .burst_count(burst_count),
    .period_sum(period_sum), .ontime_sum(ontime_sum), .done(done), .busy(busy)
  );

  always @(negedge clk) if (done) done_cnt++;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_start(input logic [1:0] m, input int tgt);
    mode_sel = m;
    burst_target = TGT_W'(tgt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input int on, input int off);
    sig_in = active_high;
    wait_n(on);
    sig_in = ~active_high;
    wait_n(off);
  endtask

  function automatic int rnd_len();
    return 1 + int'($urandom % 20);
  endfunction

  function automatic logic [63:0] sum_period(input int n);
    logic [63:0] s = 0;
    for (int i = 0; i < n; i++) s += 64'(on_len[i] + off_len[i]);
    return s;
  endfunction

  function automatic logic [63:0] sum_on(input int n);
    logic [63:0] s = 0;
    for (int i = 0; i < n; i++) s += 64'(on_len[i]);
    return s;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int d0, n, t;
    logic [63:0] keep_p, keep_o;
    void'($urandom(32'd1234));
    wait_n(4);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", 64'(busy), 0);
    check("R1 done", 64'(done), 0);
    check("R1 period", 64'(period_q), 0);
    check("R1 sum", period_sum | ontime_sum | 64'(burst_count), 0);

    // Continuous mode, both polarities (R2, R3)
    for (int pol = 1; pol >= 0; pol--) begin
      active_high = pol[0];
      sig_in = ~active_high;
      wait_n(2);
      for (int trial = 0; trial < 3; trial++) begin
        n = 1 + int'($urandom % 4);
        do_start(2'd1, 0);
        for (int i = 0; i < n; i++) begin
          on_len[i] = rnd_len(); off_len[i] = rnd_len();
          pulse(on_len[i], off_len[i]);
        end
        sig_in = active_high;
        wait_n(2);
        check("R3 R2 period", 64'(period_q), 64'(on_len[n-1] + off_len[n-1]));
        check("R3 R2 ontime", 64'(ontime_q), 64'(on_len[n-1]));
        sig_in = ~active_high;
        wait_n(2);
        do_start(2'd0, 0);
        check("R8 abort busy", 64'(busy), 0);
      end
    end

    // Only one active edge: first is skipped, pair stays zero (R3)
    active_high = 1'b1; sig_in = 1'b0; wait_n(2);
    do_start(2'd1, 0);
    check("R4 cleared period", 64'(period_q), 0);
    check("R4 cleared ontime", 64'(ontime_q), 0);
    pulse(5, 3);
    check("R3 first skipped", 64'(period_q), 0);
    pulse(6, 4);
    pulse(2, 2);
    check("R3 second", 64'(period_q), 10);
    check("R3 second on", 64'(ontime_q), 6);

    // Reselect running mode (R9)
    keep_p = 64'(period_q); keep_o = 64'(ontime_q);
    do_start(2'd1, 0);
    check("R9 period kept", 64'(period_q), keep_p);
    check("R9 ontime kept", 64'(ontime_q), keep_o);
    check("R9 busy kept", 64'(busy), 1);

    // Abort, then edges do nothing (R8, R10)
    d0 = done_cnt;
    do_start(2'd0, 0);
    pulse(7, 9); pulse(3, 4);
    check("R8 period held", 64'(period_q), keep_p);
    check("R8 ontime held", 64'(ontime_q), keep_o);
    check("R8 no done", 64'(done_cnt - d0), 0);
    check("R10 busy low", 64'(busy), 0);

    // Burst mode, both polarities (R5, R4)
    for (int pol = 0; pol < 2; pol++) begin
      active_high = pol[0];
      sig_in = ~active_high;
      wait_n(2);
      for (int trial = 0; trial < 3; trial++) begin
        t = 1 + int'($urandom % 6);
        do_start(2'd2, t);
        check("R4 burst cleared", period_sum | ontime_sum | 64'(burst_count), 0);
        for (int i = 0; i < t; i++) begin
          on_len[i] = rnd_len(); off_len[i] = rnd_len();
          pulse(on_len[i], off_len[i]);
        end
        check("R5 busy before end", 64'(busy), 1);
        d0 = done_cnt;
        sig_in = active_high;
        wait_n(3);
        check("R5 done once", 64'(done_cnt - d0), 1);
        check("R5 busy low", 64'(busy), 0);
        check("R5 count", 64'(burst_count), 64'(t));
        check("R5 period sum", period_sum, sum_period(t));
        check("R5 ontime sum", ontime_sum, sum_on(t));
        sig_in = ~active_high;
        keep_p = period_sum;
        pulse(4, 4);
        check("R10 sums held", period_sum, keep_p);
      end
    end

    // Target zero acts as one (R6)
    active_high = 1'b1; sig_in = 1'b0; wait_n(2);
    d0 = done_cnt;
    do_start(2'd2, 0);
    pulse(3, 5);
    sig_in = 1'b1;
    wait_n(3);
    check("R6 count", 64'(burst_count), 1);
    check("R6 sum", period_sum, 8);
    check("R6 done", 64'(done_cnt - d0), 1);
    sig_in = 1'b0; wait_n(2);

    // Single pulse (R7)
    for (int pol = 0; pol < 2; pol++) begin
      active_high = pol[0];
      sig_in = ~active_high;
      wait_n(2);
      for (int trial = 0; trial < 3; trial++) begin
        n = rnd_len();
        d0 = done_cnt;
        do_start(2'd3, 0);
        wait_n(rnd_len());
        pulse(n, 3);
        check("R7 ontime", 64'(ontime_q), 64'(n));
        check("R7 done", 64'(done_cnt - d0), 1);
        check("R7 stopped", 64'(busy), 0);
        pulse(n + 5, 3);
        check("R7 later ignored", 64'(ontime_q), 64'(n));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule